// File: doc/BRIEF.md
# Fractional Ratio Divider

This block divides a non-negative 16-bit dividend by a positive 16-bit divisor that is at least as large as the dividend. The ratio therefore lies between zero and one. The block returns that ratio as a signed 1.15 fixed-point fraction: the exact ratio times 32768, rounded down. The one ratio that does not fit in 1.15 format is exactly one. It is clamped to the largest positive code, 0x7FFF.

A caller pulses `start` for one cycle with both operands present. The block works out one fraction bit per clock with a restoring shift-and-subtract loop, holding `busy` high while it works. It then pulses `done` with the result on `quot`. If an operand pair breaks the preconditions, the block skips the loop. It answers at once with `err` set and a zero quotient. Operands are taken as two's-complement values.

Top module: `frac_div`

## Requirements
- R1: For a valid pair (dividend ≥ 0, divisor > 0, dividend ≤ divisor, dividend ≠ divisor), `quot` equals floor(dividend × 32768 / divisor) and `err` is 0 when `done` is high.
- R2: When dividend equals divisor (and the pair is otherwise valid), `quot` is 0x7FFF with `err` 0.
- R3: A divisor of zero or with bit 15 set (negative) is rejected: `err` is 1 and `quot` is 0x0000 when `done` is high.
- R4: A dividend with bit 15 set (negative) is rejected with `err` 1 and `quot` 0x0000.
- R5: A non-negative dividend larger than a positive divisor is rejected with `err` 1 and `quot` 0x0000.
- R6: A rejected pair raises `done` in the cycle right after the edge that accepts `start`, and `busy` never rises for it.
- R7: For an accepted valid pair, `busy` is high for exactly 15 cycles after the accepting edge. `done` is high for exactly one cycle, the cycle in which `busy` has just fallen. `busy` and `done` are never high together.
- R8: A `start` pulse while `busy` is high is ignored: the running result is unchanged and no extra `done` pulse follows.
- R9: `quot` and `err` hold their values from one `done` pulse until the next.
- R10: After synchronous reset, `busy`, `done`, `err` are 0 and `quot` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | 16 | Numerator, two's complement |
| divisor | input | 16 | Denominator, two's complement |
| busy | output | 1 | High while fraction bits are being produced |
| done | output | 1 | One-cycle pulse when `quot`/`err` are updated |
| quot | output | 16 | 1.15 fraction result |
| err | output | 1 | Set with `done` when the operands broke a precondition |

## Verification
A wrong partial remainder shows only as a wrong fraction bit. The bench therefore checks several ratios whose bit patterns differ: thirds, halves, zero and near-one. A slip in any one of the 15 steps then changes the final `quot`. A wrong iteration counter or state shows at the ports as `busy` having the wrong length or `done` arriving late. Both are measured to the exact cycle for every operation. A corrupted saturate or reject decision shows in the very `done` cycle of the pair that triggers it.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int DW = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    typedef struct packed {
        logic reject;
        logic equal;
    } verdict_t;

    function automatic logic [DW-1:0] max_pos();
        logic [DW-1:0] v;
        v = '1;
        v[DW-1] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/frac_div_check.sv
module frac_div_check
    import frac_div_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output verdict_t     verdict
);
    logic num_neg;
    logic den_bad;
    logic too_big;

    always_comb begin
        num_neg = num[W-1];
        den_bad = den[W-1] || (den == '0);
        too_big = !num_neg && !den_bad && (num > den);
        verdict.reject = num_neg || den_bad || too_big;
        verdict.equal  = !num_neg && !den_bad && (num == den);
    end
endmodule

// File: rtl/frac_div_step.sv
module frac_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] den,
    output logic [W-1:0] rem_out,
    output logic         qbit
);
    localparam int RW = W + 1;
    logic [RW-1:0] twice;
    logic [RW-1:0] diff;

    always_comb begin
        twice   = {rem_in, 1'b0};
        diff    = twice - {1'b0, den};
        qbit    = (twice >= {1'b0, den});
        rem_out = qbit ? diff[W-1:0] : twice[W-1:0];
    end
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
    import frac_div_pkg::*;
#(
    parameter int STEPS = DW - 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic reject,
    output logic load,
    output logic iter,
    output logic finish,
    output logic refuse,
    output logic busy
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    div_state_e    state;
    logic [CW-1:0] cnt;

    always_comb begin
        load   = (state == ST_IDLE) && start && !reject;
        refuse = (state == ST_IDLE) && start && reject;
        iter   = (state == ST_RUN);
        finish = (state == ST_RUN) && (cnt == LAST);
        busy   = (state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (load) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else if (finish) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (iter) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7 / R8: busy run length is counted independently of cnt
    logic [7:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assert_run_length_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && (run_len < 8'(STEPS - 1))) |=> busy);
    assert_run_limit_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < 8'(STEPS)));
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |-> !load && !refuse);
endmodule

// File: rtl/frac_div.sv
module frac_div
    import frac_div_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic         err
);
    localparam int FB = W - 1;
    localparam logic [W-1:0] SAT_VAL = {1'b0, {FB{1'b1}}};

    verdict_t     verdict;
    logic         load, iter, finish, refuse;
    logic [W-1:0] rem_q, den_q, rem_nx;
    logic [FB-1:0] frac_q;
    logic         sat_q, qbit;

    frac_div_check #(.W(W)) u_check (
        .num     (dividend),
        .den     (divisor),
        .verdict (verdict)
    );

    frac_div_ctrl #(.STEPS(FB)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .reject (verdict.reject),
        .load   (load),
        .iter   (iter),
        .finish (finish),
        .refuse (refuse),
        .busy   (busy)
    );

    frac_div_step #(.W(W)) u_step (
        .rem_in  (rem_q),
        .den     (den_q),
        .rem_out (rem_nx),
        .qbit    (qbit)
    );

    logic [FB-1:0] frac_nx;
    generate
        if (FB > 1) begin : g_shift
            assign frac_nx = {frac_q[FB-2:0], qbit};
        end else begin : g_single
            assign frac_nx = qbit;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            den_q  <= '0;
            frac_q <= '0;
            sat_q  <= 1'b0;
        end else if (load) begin
            rem_q  <= verdict.equal ? '0 : dividend;
            den_q  <= divisor;
            frac_q <= '0;
            sat_q  <= verdict.equal;
        end else if (iter) begin
            rem_q  <= rem_nx;
            frac_q <= frac_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quot <= '0;
            err  <= 1'b0;
            done <= 1'b0;
        end else if (finish) begin
            quot <= sat_q ? SAT_VAL : {1'b0, frac_nx};
            err  <= 1'b0;
            done <= 1'b1;
        end else if (refuse) begin
            quot <= '0;
            err  <= 1'b1;
            done <= 1'b1;
        end else begin
            done <= 1'b0;
        end
    end

    assert_err_zero_R3: assert property (@(posedge clk) disable iff (rst)
        err |-> (quot == '0));
    assert_sat_code_R2: assert property (@(posedge clk) disable iff (rst)
        (finish && sat_q) |=> (quot == max_pos()));
    assert_remainder_below_R1: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rem_q < den_q));
    assert_reject_fast_R6: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> ($past(start) && !$past(busy) && !busy));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_busy_done_apart_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quot) && $stable(err)));
endmodule

// File: tb/frac_div_test.sv
module frac_div_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, err;
    logic [15:0] quot;

    int total = 0;
    int bad = 0;
    bit timed_out = 0;

    always #2 clk = ~clk;

    frac_div uut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .quot(quot), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b);
        int q;
        q = (int'(a) * 32768) / int'(b);
        if (q > 32767) q = 32767;
        return q[15:0];
    endfunction

    // drive one op, return cycles until done (sampled at negedges), busy count
    task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                          output int lat, output int busy_cnt);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1; busy_cnt = 0;
        while (!done && lat < 40) begin
            if (busy) busy_cnt++;
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 err", err, 0);
        check("R10 quot", quot, 0);
    endtask

    task automatic t_valid(input logic [15:0] a, input logic [15:0] b, input string req);
        int lat, bc;
        run_op(a, b, lat, bc);
        check({req, " quot"}, quot, model(a, b));
        check({req, " err"}, err, 0);
        check("R7 latency", lat, 16);
        check("R7 busy length", bc, 15);
        @(negedge clk);
        check("R7 done one cycle", done, 0);
    endtask

    task automatic t_reject(input logic [15:0] a, input logic [15:0] b, input string req);
        int lat, bc;
        run_op(a, b, lat, bc);
        check({req, " err"}, err, 1);
        check({req, " quot zero"}, quot, 0);
        check("R6 immediate done", lat, 1);
        check("R6 busy never", bc + int'(busy), 0);
        @(negedge clk);
        check("R6 done one cycle", done, 0);
    endtask

    task automatic t_ignore_start();
        int lat;
        @(negedge clk);
        start = 1'b1; dividend = 16'd1; divisor = 16'd3;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (4) begin @(negedge clk); lat++; end
        start = 1'b1; dividend = 16'd0; divisor = 16'd0;
        @(negedge clk);
        start = 1'b0; lat++;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        check("R8 latency unaffected", lat, 16);
        check("R8 quot from first op", quot, 16'h2AAA);
        check("R8 err clear", err, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) check("R8 no extra done", done, 0);
        end
        check("R9 quot held", quot, 16'h2AAA);
    endtask

    task automatic t_hold();
        t_valid(16'd1, 16'd2, "R1 half");
        repeat (6) @(negedge clk);
        check("R9 quot held", quot, 16'h4000);
        check("R9 err held", err, 0);
        t_reject(16'd9, 16'd4, "R5 big");
        repeat (6) @(negedge clk);
        check("R9 err held", err, 1);
    endtask

    initial begin
        #100000;
        timed_out = 1;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        fork
            begin
                t_reset();
                t_valid(16'd1, 16'd3, "R1 third");
                t_valid(16'd0, 16'd5, "R1 zero");
                t_valid(16'h7FFE, 16'h7FFF, "R1 near one");
                t_valid(16'd12345, 16'd23456, "R1 mixed");
                t_valid(16'd1, 16'h7FFF, "R1 tiny");
                t_valid(16'h7FFF, 16'h7FFF, "R2 equal max");
                t_valid(16'd7, 16'd7, "R2 equal small");
                t_reject(16'd0, 16'd0, "R3 zero divisor");
                t_reject(16'd1, 16'h8001, "R3 negative divisor");
                t_reject(16'hFFFF, 16'd10, "R4 negative dividend");
                t_reject(16'd6, 16'd5, "R5 over");
                t_valid(16'd3, 16'd4, "R1 after reject");
                t_ignore_start();
                t_hold();
            end
            begin
                wait (timed_out);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule